// File: doc/BRIEF.md
# Lockable Reload Watchdog Timer

This block is a down-counting supervision timer with a software-written reload value. While it is unlocked it behaves as an ordinary timer. It counts on qualified count strobes only when the timer clock gate is on and the chip is not in a low-power state. When it reaches zero it reloads from the stored reload value.

Writing the arm bit of the command word turns it into a watchdog and locks it until reset. From then on the reload value is frozen and the arm state cannot be cleared. Counting continues on every strobe, whether the timer clock gate is on or off and whether or not the chip is in sleep.

Software keeps the watchdog quiet by issuing a service write before the count runs out. If the count underflows first, an active-high bark output rises. The counter reloads and times the bark, so the bark lasts as many strobes as one full timeout interval. The watchdog then returns to watching. A service write during a bark does not shorten it.

Top module: `lockwd_top`

## Requirements
- R1: After reset, `count_o` is 0, `bark_o` is low, `locked_o` is low and the stored reload value equals the parameter `RST_RELOAD`.
- R2: A reload-value write (`img_we_i` high) replaces the stored reload value only while `locked_o` is low. While `locked_o` is high, the write is ignored, and the next reload still uses the old value.
- R3: A command write (`cmd_we_i` high) with `cmd_arm_i` = 1 while unlocked sets `locked_o` at that edge and loads `count_o` with the stored reload value. `locked_o` then stays high until reset. A command write with `cmd_arm_i` = 0 changes nothing.
- R4: While unlocked, a strobe (`cnt_stb_i` high) decrements `count_o` only when `tclk_en_i` = 1 and `sleep_i` = 0. A qualified strobe at count 0 reloads the stored value, and `bark_o` never rises.
- R5: While locked, every strobe decrements the count, whatever the values of `tclk_en_i` and `sleep_i`.
- R6: A service write (`svc_we_i` high) reloads `count_o` from the stored value at the next edge, while unlocked and while locked without a bark. This takes priority over a strobe in the same cycle.
- R7: While locked and not barking, a strobe at count 0 with no service write raises `bark_o` at that edge and reloads `count_o` from the stored value.
- R8: While barking, each strobe decrements the count. The strobe at count 0 drops `bark_o` and reloads the count, so a bark spans exactly reload+1 strobes.
- R9: A service write during a bark is ignored: it changes neither `count_o` nor `bark_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_stb_i | input | 1 | Count strobe, one pulse per timer tick |
| tclk_en_i | input | 1 | Timer clock gate bit from power management |
| sleep_i | input | 1 | High while the chip is in power-down or sleep |
| img_we_i | input | 1 | Reload-value write strobe |
| img_wdata_i | input | W | Reload value to write |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_arm_i | input | 1 | Arm bit of the command word |
| svc_we_i | input | 1 | Service (load/store) bit write strobe |
| count_o | output | W | Current counter value |
| bark_o | output | 1 | Active-high watchdog pulse |
| locked_o | output | 1 | High once the watchdog is armed |

## Verification
The assertions assume that all inputs are synchronous to `clk` and hold known values from reset release onward. They also assume that `cnt_stb_i` is an already-qualified tick and not a raw clock. The stimulus changes every input only at the falling edge. It never issues an arm and a reload-value write in the same cycle, which keeps the order in which the loaded count sees the new reload value well defined. Service writes are placed both before underflow and inside a bark. Strobes are issued with the clock gate off and with sleep on, both before and after arming, so every branch of the count qualification is driven.

// File: rtl/lockwd_pkg.sv
package lockwd_pkg;
  // Phase of the locked watchdog: watching for underflow or barking.
  typedef enum logic [0:0] {
    PH_WATCH = 1'b0,
    PH_BARK  = 1'b1
  } wd_phase_e;
endpackage

// File: rtl/lockwd_cfg.sv
module lockwd_cfg #(
  parameter int W          = 16,
  parameter int RST_RELOAD = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         img_we,
  input  logic [W-1:0] img_wdata,
  input  logic         cmd_we,
  input  logic         cmd_arm,
  output logic [W-1:0] reload_q,
  output logic         locked_q,
  output logic         arm_evt
);
  localparam logic [W-1:0] RELOAD_INIT = W'(RST_RELOAD);

  // Arming happens once; later arm writes see the lock already set.
  assign arm_evt = cmd_we && cmd_arm && !locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= RELOAD_INIT;
      locked_q <= 1'b0;
    end else begin
      if (img_we && !locked_q) reload_q <= img_wdata;
      if (arm_evt) locked_q <= 1'b1;
    end
  end

  // R2: once locked, the reload value never moves
  a_r2_reload_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(reload_q));

  // R3: lock is sticky until reset
  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);

  // R3: an arm write while unlocked locks at the next edge
  a_r3_arm_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_arm) |=> locked_q);
endmodule

// File: rtl/lockwd_gate.sv
module lockwd_gate (
  input  logic stb,
  input  logic tclk_en,
  input  logic sleep,
  input  logic locked,
  output logic adv
);
  // Ordinary timer: gated by the clock-enable bit and stopped in sleep.
  // Armed watchdog: every strobe counts.
  function automatic logic qualify(input logic s, input logic g,
                                   input logic slp, input logic lk);
    return s && (lk || (g && !slp));
  endfunction

  assign adv = qualify(stb, tclk_en, sleep, locked);
endmodule

// File: rtl/lockwd_core.sv
module lockwd_core
  import lockwd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         svc,
  input  logic         arm_evt,
  input  logic         locked,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         bark
);
  localparam logic [W-1:0] ZERO = '0;

  function automatic logic at_terminal(input logic [W-1:0] c);
    return c == ZERO;
  endfunction

  function automatic logic [W-1:0] step_down(input logic [W-1:0] c);
    return c - W'(1);
  endfunction

  wd_phase_e    ph_q, ph_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         underflow;   // strobe while watching at zero
  logic         bark_done;   // strobe while barking at zero

  assign underflow = (ph_q == PH_WATCH) && adv && at_terminal(cnt_q) && !svc;
  assign bark_done = (ph_q == PH_BARK) && adv && at_terminal(cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (arm_evt) begin
      cnt_d = reload;
    end else if (ph_q == PH_WATCH) begin
      if (svc) begin
        cnt_d = reload;
      end else if (adv) begin
        if (at_terminal(cnt_q)) begin
          cnt_d = reload;
          if (locked) ph_d = PH_BARK;
        end else begin
          cnt_d = step_down(cnt_q);
        end
      end
    end else begin
      if (adv) begin
        if (at_terminal(cnt_q)) begin
          cnt_d = reload;
          ph_d  = PH_WATCH;
        end else begin
          cnt_d = step_down(cnt_q);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      ph_q  <= PH_WATCH;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign count = cnt_q;
  assign bark  = (ph_q == PH_BARK);

  // R4: no bark without the lock
  a_r4_bark_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    bark |-> locked);

  // R7: locked underflow raises the bark with the count reloaded
  a_r7_bark_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && underflow) |=> (bark && count == $past(reload)));

  // R8: the strobe at zero during a bark ends it
  a_r8_bark_ends: assert property (@(posedge clk) disable iff (!rst_n)
    bark_done |=> (!bark && count == $past(reload)));

  // R9: a service write cannot shorten a bark
  a_r9_svc_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (bark && svc && !adv) |=> (bark && $stable(count)));

  // R6: service while watching reloads the count
  a_r6_svc_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!bark && svc && !arm_evt) |=> (count == $past(reload)));
endmodule

// File: rtl/lockwd_top.sv
module lockwd_top #(
  parameter int W          = 16,
  parameter int RST_RELOAD = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_stb_i,
  input  logic         tclk_en_i,
  input  logic         sleep_i,
  input  logic         img_we_i,
  input  logic [W-1:0] img_wdata_i,
  input  logic         cmd_we_i,
  input  logic         cmd_arm_i,
  input  logic         svc_we_i,
  output logic [W-1:0] count_o,
  output logic         bark_o,
  output logic         locked_o
);
  logic [W-1:0] reload_w;
  logic         locked_w;
  logic         arm_evt_w;
  logic         adv_w;

  lockwd_cfg #(.W(W), .RST_RELOAD(RST_RELOAD)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .img_we    (img_we_i),
    .img_wdata (img_wdata_i),
    .cmd_we    (cmd_we_i),
    .cmd_arm   (cmd_arm_i),
    .reload_q  (reload_w),
    .locked_q  (locked_w),
    .arm_evt   (arm_evt_w)
  );

  lockwd_gate u_gate (
    .stb     (cnt_stb_i),
    .tclk_en (tclk_en_i),
    .sleep   (sleep_i),
    .locked  (locked_w),
    .adv     (adv_w)
  );

  lockwd_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv_w),
    .svc     (svc_we_i),
    .arm_evt (arm_evt_w),
    .locked  (locked_w),
    .reload  (reload_w),
    .count   (count_o),
    .bark    (bark_o)
  );

  assign locked_o = locked_w;

  // R4: unlocked with the gate off or in sleep, the count holds
  a_r4_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_w && (!tclk_en_i || sleep_i) && !svc_we_i && !cmd_we_i)
      |=> $stable(count_o));

  // R5: locked strobes move the count whatever the gate and sleep
  a_r5_locked_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_w && cnt_stb_i && !svc_we_i && count_o != '0)
      |=> (count_o == $past(count_o) - W'(1)));
endmodule

// File: tb/sim_lockwd_top.sv
module sim_lockwd_top;
  localparam int W   = 16;
  localparam int RST = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 0, tclk = 0, slp = 0, imgwe = 0, cmdwe = 0, arm = 0, svc = 0;
  logic [W-1:0] imgd = '0;
  logic [W-1:0] count_o;
  logic bark_o, locked_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lockwd_top #(.W(W), .RST_RELOAD(RST)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_stb_i(stb), .tclk_en_i(tclk),
    .sleep_i(slp), .img_we_i(imgwe), .img_wdata_i(imgd), .cmd_we_i(cmdwe),
    .cmd_arm_i(arm), .svc_we_i(svc), .count_o(count_o), .bark_o(bark_o),
    .locked_o(locked_o)
  );

  // Behavioural reference model
  int m_cnt, m_img, m_lock, m_bark;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_img = RST; m_lock = 0; m_bark = 0;
    end else begin
      int nimg;
      bit go;
      go = stb && (m_lock != 0 || (tclk && !slp));
      nimg = (imgwe && m_lock == 0) ? int'(imgd) : m_img;
      if (cmdwe && arm && m_lock == 0) begin
        m_cnt = m_img; m_lock = 1;
      end else if (m_bark == 0 && svc) begin
        m_cnt = m_img;
      end else if (go) begin
        if (m_cnt == 0) begin
          m_cnt = m_img;
          if (m_lock != 0) m_bark = 1 - m_bark;
        end else m_cnt = m_cnt - 1;
      end
      m_img = nimg;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk(int'(count_o) == m_cnt, "R4/R5/R6 model count", int'(count_o), m_cnt);
    chk(int'(bark_o) == m_bark, "R7/R8 model bark", int'(bark_o), m_bark);
    chk(int'(locked_o) == m_lock, "R3 model lock", int'(locked_o), m_lock);
  endtask

  task automatic idle_inputs();
    stb = 0; imgwe = 0; cmdwe = 0; arm = 0; svc = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
    cmp_model();
    idle_inputs();
  endtask

  task automatic ticks(input int n, input bit g, input bit s);
    for (int i = 0; i < n; i++) begin
      stb = 1; tclk = g; slp = s;
      cyc();
    end
  endtask

  task automatic wr_img(input int v);
    imgwe = 1; imgd = W'(v); cyc();
  endtask

  task automatic wr_cmd(input bit a);
    cmdwe = 1; arm = a; cyc();
  endtask

  task automatic service(input bit with_stb);
    svc = 1; stb = with_stb; cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int blen;
    repeat (3) @(negedge clk);
    chk(count_o == 0, "R1 count", int'(count_o), 0);
    chk(bark_o == 0, "R1 bark", int'(bark_o), 0);
    chk(locked_o == 0, "R1 lock", int'(locked_o), 0);
    rst_n = 1;
    @(negedge clk);
    service(0);
    chk(count_o == RST, "R1 reset reload value", int'(count_o), RST);

    // unlocked timer
    wr_img(3);
    service(0);
    chk(count_o == 3, "R6 unlocked service", int'(count_o), 3);
    ticks(2, 1, 0);
    chk(count_o == 1, "R4 gated count", int'(count_o), 1);
    ticks(3, 0, 0);
    chk(count_o == 1, "R4 gate off holds", int'(count_o), 1);
    ticks(3, 1, 1);
    chk(count_o == 1, "R4 sleep holds", int'(count_o), 1);
    ticks(2, 1, 0);
    chk(count_o == 3, "R4 wrap reload", int'(count_o), 3);
    chk(bark_o == 0, "R4 no bark unlocked", int'(bark_o), 0);
    wr_cmd(0);
    chk(locked_o == 0, "R3 arm=0 ignored", int'(locked_o), 0);

    // arming
    wr_img(4);
    ticks(1, 1, 0);
    wr_cmd(1);
    chk(locked_o == 1, "R3 armed", int'(locked_o), 1);
    chk(count_o == 4, "R3 arm loads count", int'(count_o), 4);
    wr_img(9);
    service(0);
    chk(count_o == 4, "R2 locked write ignored", int'(count_o), 4);
    ticks(2, 0, 1);
    chk(count_o == 2, "R5 counts in sleep gate off", int'(count_o), 2);
    ticks(1, 0, 0);
    chk(count_o == 1, "R5 counts gate off", int'(count_o), 1);
    service(1);
    chk(count_o == 4, "R6 service beats strobe", int'(count_o), 4);
    ticks(4, 1, 0);
    chk(count_o == 0 && bark_o == 0, "R7 at zero no bark yet", int'(bark_o), 0);
    ticks(1, 0, 1);
    chk(bark_o == 1, "R7 bark rises", int'(bark_o), 1);
    chk(count_o == 4, "R7 bark reload", int'(count_o), 4);
    service(0);
    chk(bark_o == 1 && count_o == 4, "R9 service during bark", int'(count_o), 4);

    // measure the bark in strobes, with gaps between strobes
    blen = 1;
    for (int i = 0; i < 40 && bark_o; i++) begin
      if (i % 2 == 0) begin stb = 1; tclk = 0; slp = 0; end
      cyc();
      if (i % 2 == 0 && bark_o) blen++;
    end
    chk(blen == 5, "R8 bark spans reload+1 strobes", blen, 5);
    chk(bark_o == 0 && count_o == 4, "R8 bark end reload", int'(count_o), 4);
    wr_cmd(0);
    chk(locked_o == 1, "R3 lock sticky", int'(locked_o), 1);
    for (int k = 0; k < 3; k++) begin
      ticks(3, 1, 0);
      service(0);
    end
    chk(bark_o == 0 && count_o == 4, "R6 serviced no bark", int'(bark_o), 0);

    // reset clears the lock and the reload value
    rst_n = 0;
    @(negedge clk);
    cmp_model();
    rst_n = 1;
    @(negedge clk);
    chk(locked_o == 0, "R1 reset clears lock", int'(locked_o), 0);
    service(0);
    chk(count_o == RST, "R1 reload value restored", int'(count_o), RST);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule